// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Packed Status Word

This block performs one two-operand arithmetic or bitwise operation per execute strobe, on either a full 16-bit word or the low byte of each operand. On the same clock edge it registers the result and a set of status bits: carry/borrow, low-byte parity, nibble-boundary auxiliary carry, zero, sign and signed overflow. Add-with-carry and subtract-with-borrow take the carry bit that the previous operation left behind, so wide values can be processed as a chain of word or byte steps.

Three control bits (single-step trap, interrupt enable and string direction) sit alongside the status bits. Each has its own set and clear strobe, and these act whether or not an operation runs. All bits are presented as one 16-bit word in a fixed layout, so that a neighbouring decoder can use the word as it stands. Instruction decode, shifts, rotates, multiply, divide and decimal adjustment are handled elsewhere.

Top module: `flagword_alu`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) makes result 0x0000 and the flag word 0x0002.
- R2: When exec_en is high at a clock edge, result takes the value of the selected operation: op_sel 0 = a+b, 1 = a+b+C, 2 = a-b, 3 = a-b-C, 4 = a AND b, 5 = a OR b, 6 = a XOR b. It is visible from that edge onward.
- R3: When byte_mode is high, only a[7:0] and b[7:0] are used and result[15:8] is 0. Carry is the carry out of (or the borrow into) bit 7, sign is result bit 7, overflow is the signed overflow of an 8-bit operation, and zero tests the low byte.
- R4: For arithmetic operations, C (flag bit 0) is 1 on a carry out of the operand's top bit for an add, or on a borrow for a subtract. Otherwise it is 0.
- R5: For arithmetic operations, O (flag bit 11) is 1 exactly when the two's-complement result cannot be represented in the operand width.
- R6: For arithmetic operations, A (flag bit 4) is 1 exactly when bit 3 carries into bit 4 (add) or bit 4 borrows from bit 3 (subtract).
- R7: P (flag bit 2) is 1 when result[7:0] holds an even number of ones, including zero ones, and 0 otherwise. It ignores result[15:8].
- R8: Z (flag bit 6) is 1 exactly when the result within the operand width is zero. S (flag bit 7) equals the result's top bit within the operand width.
- R9: Logic operations (op_sel 4 to 6) clear C, A and O.
- R10: With exec_en low, or with op_sel 7, result and the six status flags keep their values.
- R11: Strobes set and clear T (bit 8), I (bit 9) and D (bit 10). They act at the clock edge independently of exec_en, and clear wins when set and clear of the same bit are both high.
- R12: Flag word layout: C=0, P=2, A=4, Z=6, S=7, T=8, I=9, D=10, O=11. Bit 1 always reads 1, and bits 3, 5 and 12 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe: register the result and status flags this edge |
| op_sel | input | 3 | Operation select (encoding in R2; 7 = no operation) |
| byte_mode | input | 1 | 1 = operate on the low bytes, 0 = full word |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| trap_set | input | 1 | Set T |
| trap_clr | input | 1 | Clear T |
| ien_set | input | 1 | Set I |
| ien_clr | input | 1 | Clear I |
| dir_set | input | 1 | Set D |
| dir_clr | input | 1 | Clear D |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered flag word (layout in R12) |

## Verification
The assertions assume that every input is a known level at each clock edge and that op_sel 7 is the only code outside the operation set. They also assume the control strobes may arrive in any combination, including set and clear together. The stimulus drives every input on the falling edge and never leaves a value unknown. It covers byte and word operands, and in byte mode it places non-zero upper bytes on the operands. It reaches op_sel 7 only on purpose, as the no-operation case, and it holds the control strobes low during the operand sweeps.

// File: rtl/fw_pkg.sv
package fw_pkg;

    localparam int FLAG_W = 16;

    // Flag word bit positions
    localparam int POS_C = 0;
    localparam int POS_P = 2;
    localparam int POS_A = 4;
    localparam int POS_Z = 6;
    localparam int POS_S = 7;
    localparam int POS_T = 8;
    localparam int POS_I = 9;
    localparam int POS_D = 10;
    localparam int POS_O = 11;
    localparam int POS_ONE = 1;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_NONE = 3'd7
    } fw_op_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic tf;
        logic ief;
        logic df;
        logic of;
    } fw_flags_t;

    function automatic logic [FLAG_W-1:0] fw_pack(input fw_flags_t f);
        logic [FLAG_W-1:0] w;
        w          = '0;
        w[POS_ONE] = 1'b1;
        w[POS_C]   = f.cf;
        w[POS_P]   = f.pf;
        w[POS_A]   = f.af;
        w[POS_Z]   = f.zf;
        w[POS_S]   = f.sf;
        w[POS_T]   = f.tf;
        w[POS_I]   = f.ief;
        w[POS_D]   = f.df;
        w[POS_O]   = f.of;
        return w;
    endfunction

endpackage

// File: rtl/fw_arith.sv
module fw_arith #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              use_cin,
    input  logic              cin,
    input  logic              narrow,
    output logic [DATA_W-1:0] res,
    output logic              cy,
    output logic              ov,
    output logic              ac
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] bx;
    logic              ci;
    logic [DATA_W:0]   wide_sum;
    logic [HALF:0]     nar_sum;
    logic              cout;
    logic              msb_a;
    logic              msb_b;
    logic              msb_r;

    always_comb begin
        // Subtraction is a + ~b + 1 - borrow_in; carry out then means "no borrow"
        bx       = sub ? ~b : b;
        ci       = sub ? ~(use_cin & cin) : (use_cin & cin);
        wide_sum = {1'b0, a} + {1'b0, bx} + {{DATA_W{1'b0}}, ci};
        nar_sum  = {1'b0, a[HALF-1:0]} + {1'b0, bx[HALF-1:0]} + {{HALF{1'b0}}, ci};
        if (narrow) begin
            res   = {{(DATA_W-HALF){1'b0}}, nar_sum[HALF-1:0]};
            cout  = nar_sum[HALF];
            msb_a = a[HALF-1];
            msb_b = bx[HALF-1];
            msb_r = nar_sum[HALF-1];
        end else begin
            res   = wide_sum[DATA_W-1:0];
            cout  = wide_sum[DATA_W];
            msb_a = a[DATA_W-1];
            msb_b = bx[DATA_W-1];
            msb_r = wide_sum[DATA_W-1];
        end
        cy = cout ^ sub;
        ov = (msb_a == msb_b) && (msb_r != msb_a);
        // The bit-4 sum reveals the carry or borrow crossing from bit 3
        ac = a[4] ^ b[4] ^ res[4];
    end
endmodule

// File: rtl/fw_logic.sv
module fw_logic #(
    parameter int DATA_W = 16
) (
    input  fw_pkg::fw_op_e    op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              narrow,
    output logic [DATA_W-1:0] res
);
    import fw_pkg::*;
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] keep;

    always_comb begin
        unique case (op)
            OP_AND:  raw = a & b;
            OP_OR:   raw = a | b;
            OP_XOR:  raw = a ^ b;
            default: raw = '0;
        endcase
        keep = narrow ? {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}} : {DATA_W{1'b1}};
        res  = raw & keep;
    end
endmodule

// File: rtl/fw_status.sv
module fw_status #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] res,
    input  logic              narrow,
    output logic              zf,
    output logic              sf,
    output logic              pf
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        if (narrow) begin
            zf = (res[HALF-1:0] == '0);
            sf = res[HALF-1];
        end else begin
            zf = (res == '0);
            sf = res[DATA_W-1];
        end
        pf = ~(^res[7:0]);
    end
endmodule

// File: rtl/flagword_alu.sv
module flagword_alu #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [2:0]        op_sel,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              trap_set,
    input  logic              trap_clr,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              dir_set,
    input  logic              dir_clr,
    output logic [DATA_W-1:0] result,
    output logic [15:0]       flags
);
    import fw_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        fw_flags_t         fl;
    } fw_state_t;

    fw_state_t state_d;
    fw_state_t state_q;

    fw_op_e            op;
    logic              is_arith;
    logic              do_exec;
    logic [DATA_W-1:0] ar_res;
    logic              ar_cy;
    logic              ar_ov;
    logic              ar_ac;
    logic [DATA_W-1:0] lg_res;
    logic [DATA_W-1:0] sel_res;
    logic              st_zf;
    logic              st_sf;
    logic              st_pf;

    assign op       = fw_op_e'(op_sel);
    assign is_arith = (op_sel[2] == 1'b0);
    assign do_exec  = exec_en && (op != OP_NONE);

    fw_arith #(.DATA_W(DATA_W)) u_arith (
        .a       (opa),
        .b       (opb),
        .sub     (op_sel[1]),
        .use_cin (op_sel[0]),
        .cin     (state_q.fl.cf),
        .narrow  (byte_mode),
        .res     (ar_res),
        .cy      (ar_cy),
        .ov      (ar_ov),
        .ac      (ar_ac)
    );

    fw_logic #(.DATA_W(DATA_W)) u_logic (
        .op     (op),
        .a      (opa),
        .b      (opb),
        .narrow (byte_mode),
        .res    (lg_res)
    );

    assign sel_res = is_arith ? ar_res : lg_res;

    fw_status #(.DATA_W(DATA_W)) u_status (
        .res    (sel_res),
        .narrow (byte_mode),
        .zf     (st_zf),
        .sf     (st_sf),
        .pf     (st_pf)
    );

    always_comb begin
        state_d = state_q;
        if (do_exec) begin
            state_d.res   = sel_res;
            state_d.fl.zf = st_zf;
            state_d.fl.sf = st_sf;
            state_d.fl.pf = st_pf;
            state_d.fl.cf = is_arith ? ar_cy : 1'b0;
            state_d.fl.of = is_arith ? ar_ov : 1'b0;
            state_d.fl.af = is_arith ? ar_ac : 1'b0;
        end
        // Control bits: clear has priority over set
        if (trap_clr)      state_d.fl.tf  = 1'b0;
        else if (trap_set) state_d.fl.tf  = 1'b1;
        if (ien_clr)       state_d.fl.ief = 1'b0;
        else if (ien_set)  state_d.fl.ief = 1'b1;
        if (dir_clr)       state_d.fl.df  = 1'b0;
        else if (dir_set)  state_d.fl.df  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.res;
    assign flags  = fw_pack(state_q.fl);

endmodule

// File: rtl/fw_checker.sv
module fw_checker (
    input logic        clk,
    input logic        rst,
    input logic        exec_en,
    input logic [2:0]  op_sel,
    input logic        byte_mode,
    input logic        trap_set,
    input logic        trap_clr,
    input logic        ien_set,
    input logic        ien_clr,
    input logic        dir_set,
    input logic        dir_clr,
    input logic [15:0] result,
    input logic [15:0] flags
);
    logic go;
    assign go = exec_en && (op_sel != 3'd7);

    a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(result));

    a_r10_hold_status: assert property (@(posedge clk) disable iff (rst)
        !go |=> ($stable(flags[7:0]) && $stable(flags[11])));

    a_r9_logic_clears: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_sel[2] && (op_sel != 3'd7)) |=> (!flags[0] && !flags[4] && !flags[11]));

    a_r7_zero_even: assert property (@(posedge clk) disable iff (rst)
        flags[6] |-> flags[2]);

    a_r8_zero_word: assert property (@(posedge clk) disable iff (rst)
        go |=> (flags[6] == (result == 16'h0000)));

    a_r8_sign_word: assert property (@(posedge clk) disable iff (rst)
        (go && !byte_mode) |=> (flags[7] == result[15]));

    a_r3_sign_byte: assert property (@(posedge clk) disable iff (rst)
        (go && byte_mode) |=> (flags[7] == result[7]));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (go && byte_mode) |=> (result[15:8] == 8'h00));

    a_r11_trap_set: assert property (@(posedge clk) disable iff (rst)
        (trap_set && !trap_clr) |=> flags[8]);

    a_r11_trap_clr: assert property (@(posedge clk) disable iff (rst)
        trap_clr |=> !flags[8]);

    a_r11_ien_clr: assert property (@(posedge clk) disable iff (rst)
        ien_clr |=> !flags[9]);

    a_r11_dir_clr: assert property (@(posedge clk) disable iff (rst)
        dir_clr |=> !flags[10]);

    a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !(trap_set || trap_clr || ien_set || ien_clr || dir_set || dir_clr)
            |=> $stable(flags[10:8]));
endmodule

bind flagword_alu fw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .exec_en   (exec_en),
    .op_sel    (op_sel),
    .byte_mode (byte_mode),
    .trap_set  (trap_set),
    .trap_clr  (trap_clr),
    .ien_set   (ien_set),
    .ien_clr   (ien_clr),
    .dir_set   (dir_set),
    .dir_clr   (dir_clr),
    .result    (result),
    .flags     (flags)
);

// File: tb/flagword_alu_bench.sv
module flagword_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        trap_set = 0, trap_clr = 0, ien_set = 0, ien_clr = 0, dir_set = 0, dir_clr = 0;
    logic [15:0] result;
    logic [15:0] flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the registered state
    int m_res = 0;
    int m_c = 0, m_p = 0, m_a = 0, m_z = 0, m_s = 0, m_o = 0;
    int m_t = 0, m_i = 0, m_d = 0;

    always #5 clk = ~clk;

    flagword_alu u_flagword_alu (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel), .byte_mode(byte_mode),
        .opa(opa), .opb(opb),
        .trap_set(trap_set), .trap_clr(trap_clr), .ien_set(ien_set), .ien_clr(ien_clr),
        .dir_set(dir_set), .dir_clr(dir_clr),
        .result(result), .flags(flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_word();
        return (m_c << 0) | (1 << 1) | (m_p << 2) | (m_a << 4) | (m_z << 6) | (m_s << 7)
             | (m_t << 8) | (m_i << 9) | (m_d << 10) | (m_o << 11);
    endfunction

    // Arithmetic reference: integer arithmetic on the operand width
    task automatic model_op(input int a, input int b, input int op, input int bm);
        int w, mask, top, aa, bb, ci, r, sa, sb, ss, s;
        w    = bm ? 8 : 16;
        mask = (1 << w) - 1;
        top  = 1 << (w - 1);
        aa   = a & mask;
        bb   = b & mask;
        ci   = (op == 1 || op == 3) ? m_c : 0;
        sa   = (aa & top) != 0 ? aa - (1 << w) : aa;
        sb   = (bb & top) != 0 ? bb - (1 << w) : bb;
        r    = 0;
        case (op)
            0, 1: begin
                s = aa + bb + ci; r = s & mask; m_c = (s > mask) ? 1 : 0;
                ss = sa + sb + ci; m_o = (ss > top - 1 || ss < -top) ? 1 : 0;
                m_a = (((aa & 15) + (bb & 15) + ci) > 15) ? 1 : 0;
            end
            2, 3: begin
                s = aa - bb - ci; r = s & mask; m_c = (s < 0) ? 1 : 0;
                ss = sa - sb - ci; m_o = (ss > top - 1 || ss < -top) ? 1 : 0;
                m_a = (((aa & 15) - (bb & 15) - ci) < 0) ? 1 : 0;
            end
            4: begin r = aa & bb; m_c = 0; m_o = 0; m_a = 0; end
            5: begin r = aa | bb; m_c = 0; m_o = 0; m_a = 0; end
            default: begin r = aa ^ bb; m_c = 0; m_o = 0; m_a = 0; end
        endcase
        m_res = r;
        m_z   = (r == 0) ? 1 : 0;
        m_s   = ((r & top) != 0) ? 1 : 0;
        m_p   = ($countones(r[7:0]) % 2 == 0) ? 1 : 0;
    endtask

    task automatic run_vec(input int a, input int b, input int op, input int bm);
        bit lg;
        opa = a[15:0]; opb = b[15:0]; op_sel = op[2:0]; byte_mode = bm[0]; exec_en = 1'b1;
        model_op(a, b, op, bm);
        @(posedge clk);
        @(negedge clk);
        exec_en = 1'b0;
        lg = (op >= 4);
        chk(bm ? "R3 result" : "R2 result", int'(result), m_res);
        chk(lg ? "R9 C" : (bm ? "R3 C" : "R4 C"), int'(flags[0]), m_c);
        chk(lg ? "R9 O" : (bm ? "R3 O" : "R5 O"), int'(flags[11]), m_o);
        chk(lg ? "R9 A" : "R6 A", int'(flags[4]), m_a);
        chk("R7 P", int'(flags[2]), m_p);
        chk("R8 Z", int'(flags[6]), m_z);
        chk("R8 S", int'(flags[7]), m_s);
        chk("R12 word", int'(flags), exp_word());
    endtask

    task automatic strobe(input int t_s, input int t_c, input int i_s, input int i_c,
                          input int d_s, input int d_c, input int ex);
        trap_set = t_s[0]; trap_clr = t_c[0]; ien_set = i_s[0]; ien_clr = i_c[0];
        dir_set = d_s[0]; dir_clr = d_c[0]; exec_en = ex[0];
        if (t_c != 0) m_t = 0; else if (t_s != 0) m_t = 1;
        if (i_c != 0) m_i = 0; else if (i_s != 0) m_i = 1;
        if (d_c != 0) m_d = 0; else if (d_s != 0) m_d = 1;
        @(posedge clk);
        @(negedge clk);
        trap_set = 0; trap_clr = 0; ien_set = 0; ien_clr = 0; dir_set = 0; dir_clr = 0; exec_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int wl[16];
        wl = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h000F, 16'h0010, 16'h00FF,
               16'h0100, 16'h5555, 16'hAAAA, 16'h1234, 16'hFEDC, 16'h8001, 16'h7FFE, 16'h0F0F};

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 result", int'(result), 0);
        chk("R1 flags", int'(flags), 16'h0002);

        // R11 / R12: control bits and their positions
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R11 T set", int'(flags), 16'h0102);
        strobe(0, 0, 1, 0, 0, 0, 0);
        chk("R11 I set", int'(flags), 16'h0302);
        strobe(0, 0, 0, 0, 1, 0, 0);
        chk("R12 D position", int'(flags), 16'h0702);
        strobe(0, 0, 0, 0, 1, 1, 0);
        chk("R11 clear wins", int'(flags), 16'h0302);
        strobe(1, 1, 0, 1, 1, 0, 0);
        chk("R11 mixed", int'(flags), 16'h0402);
        strobe(1, 0, 0, 0, 0, 0, 0);
        chk("R11 T set no exec", int'(flags), 16'h0502);

        // R2, R4-R9: word sweep over corner operands
        for (int op = 0; op < 7; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run_vec(wl[i], wl[j], op, 0);

        // R3: byte sweep with noisy upper bytes
        for (int op = 0; op < 7; op++)
            for (int a = 0; a < 256; a += 3)
                for (int b = 0; b < 256; b += 7)
                    run_vec(a | 16'hA500, b | ((a & 16'h00FF) << 8), op, 1);

        // R10: hold with exec_en low and with op 7
        run_vec(16'hFFFF, 16'h0001, 0, 0);
        opa = 16'h1234; opb = 16'h4321; op_sel = 3'd6; byte_mode = 1'b1; exec_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10 result exec low", int'(result), m_res);
        chk("R10 flags exec low", int'(flags), exp_word());
        op_sel = 3'd7; exec_en = 1'b1;
        @(posedge clk); @(negedge clk);
        exec_en = 1'b0;
        chk("R10 result op7", int'(result), m_res);
        chk("R10 flags op7", int'(flags), exp_word());
        // carry preserved across the hold feeds ADC
        run_vec(16'h0000, 16'h0000, 1, 0);
        chk("R4 ADC after hold", int'(result), 1);

        // R11: strobes together with an operation
        strobe(0, 1, 1, 0, 0, 1, 1);
        chk("R11 with exec", int'(flags[10:8]), 3'b010);

        // R1: reset after activity
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1 reset again result", int'(result), 0);
        chk("R1 reset again flags", int'(flags), 16'h0002);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule